// File: doc/BRIEF.md
# Loss-Tracking Benes Permutation Fabric

This block steers N data words, N a power of two, through a rearrangeable Benes network of two-by-two switching elements. Each element takes one configuration bit. An outside scheduler computes the bits for the permutation it wants. The fabric does not solve routing. It applies the configuration it is given, routes every word to its output line, and reports a degradation index for each output line. The index counts how many elements on the path that reached that line were in their high-loss setting.

Two element flavours exist, and the parameter `MIRROR` picks one of them for the whole plane. In a normal plane, the straight-through (bar) setting is the lossy one. In a mirrored plane, the exchange (cross) setting is the lossy one. A path that meets X lossy elements in one plane therefore meets S-X in the other, where S = 2*log2(N)-1 is the number of stages.

The whole path is combinational, and one output register stage follows it. The block uses a valid/ready stream with a single result register:
- A word set transfers when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the register is empty or its result is leaving in the same cycle.
- A held result stays unchanged until `out_ready` takes it.

Top module: `benes_loss_fabric`

## Requirements
- R1: Each input word appears on exactly one output line, the line reached by following the configured elements and the inter-stage wiring. No word is duplicated or lost.
- R2: Configuration encoding: bit s*(N/2)+e drives element e of stage s, and that element joins lines 2e and 2e+1. A bit value of 1 selects bar (2e to 2e, 2e+1 to 2e+1) and 0 selects cross.
- R3: Between stage s and s+1, line p moves as follows:
  - For s < log2(N)-1: take blocks of size B = N>>s. Position q inside the block goes to (q mod 2)*B/2 + q/2.
  - For the later stages: take B = N>>(S-2-s). Position q goes to 2*(q mod B/2) + q/(B/2).
- R4: With `MIRROR`=0, an output's index equals the number of bar elements on its path.
- R5: With `MIRROR`=1, an output's index equals the number of cross elements on its path. This is S minus the `MIRROR`=0 value for the same configuration.
- R6: No index exceeds S. With all bits at 1, every index is S in the normal plane and 0 in the mirrored plane.
- R7: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted set yields `out_valid`=1 with its results in the next cycle. When no set is accepted and the held result leaves, `out_valid` drops.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_deg` and `out_valid` stay unchanged whatever the inputs do.
- R9: During and directly after reset, `out_valid` is 0.
- R10: The indices of one result sum to twice the number of lossy elements in the configuration that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input set offered |
| in_ready | output | 1 | Fabric can take a set this cycle |
| in_data | input | N*W | Input words, lane i at bits i*W |
| in_cfg | input | (S)*(N/2) | Element settings, 1 = bar |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | N*W | Routed words, line o at bits o*W |
| out_deg | output | N*IW | Degradation index per output line, IW = clog2(2*log2(N)) |

## Verification
The bench builds two 4-port fabrics, one normal and one mirrored, with 8-bit words. Both receive the same configurations, which lets it sweep all 64 settings of the three-stage network and compare the two planes' indices lane by lane. An 8-port normal fabric gets 264 random configurations to exercise the five-stage wiring, including the recursive split at a second depth. Back-pressure is tested on the 4-port fabric by changing inputs under a stalled consumer.

// File: rtl/benes_pkg.sv
package benes_pkg;

  // Destination line in stage s+1 for line p leaving stage s of an n-port fabric.
  function automatic int next_line(int n, int s, int p);
    int lg, st, blk, half, base, q, m;
    lg   = $clog2(n);
    st   = 2 * lg - 1;
    if (s < lg - 1) begin
      blk  = n >> s;
      half = blk / 2;
      base = p - (p % blk);
      q    = p % blk;
      return base + (q % 2) * half + q / 2;
    end
    m    = st - 2 - s;
    blk  = n >> m;
    half = blk / 2;
    base = p - (p % blk);
    q    = p % blk;
    return base + 2 * (q % half) + q / half;
  endfunction

endpackage

// File: rtl/benes_element.sv
module benes_element #(
  parameter int W      = 8,
  parameter int IW     = 3,
  parameter bit MIRROR = 1'b0
) (
  input  logic          bar,
  input  logic [W-1:0]  a_data,
  input  logic [W-1:0]  b_data,
  input  logic [IW-1:0] a_deg,
  input  logic [IW-1:0] b_deg,
  output logic [W-1:0]  x_data,
  output logic [W-1:0]  y_data,
  output logic [IW-1:0] x_deg,
  output logic [IW-1:0] y_deg
);
  logic lossy;

  // Normal element: bar is lossy. Mirrored element: cross is lossy.
  assign lossy = bar ^ MIRROR;

  always_comb begin
    if (bar) begin
      x_data = a_data;
      y_data = b_data;
      x_deg  = a_deg + IW'(lossy);
      y_deg  = b_deg + IW'(lossy);
    end else begin
      x_data = b_data;
      y_data = a_data;
      x_deg  = b_deg + IW'(lossy);
      y_deg  = a_deg + IW'(lossy);
    end
  end
endmodule

// File: rtl/benes_network.sv
module benes_network #(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter bit MIRROR = 1'b0,
  localparam int LG     = $clog2(N),
  localparam int STAGES = 2 * LG - 1,
  localparam int HALF   = N / 2,
  localparam int RINGS  = 2 * N * LG - N,
  localparam int CFGW   = RINGS / 2,
  localparam int IW     = $clog2(2 * LG)
) (
  input  logic [N*W-1:0]  in_data,
  input  logic [CFGW-1:0] cfg,
  output logic [N*W-1:0]  out_data,
  output logic [N*IW-1:0] out_deg
);
  logic [W-1:0]  pre_d  [STAGES][N];
  logic [IW-1:0] pre_x  [STAGES][N];
  logic [W-1:0]  post_d [STAGES][N];
  logic [IW-1:0] post_x [STAGES][N];

  for (genvar p = 0; p < N; p++) begin : g_entry
    assign pre_d[0][p] = in_data[p*W +: W];
    assign pre_x[0][p] = '0;
    assign out_data[p*W +: W]   = post_d[STAGES-1][p];
    assign out_deg[p*IW +: IW]  = post_x[STAGES-1][p];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar e = 0; e < HALF; e++) begin : g_elem
      benes_element #(.W(W), .IW(IW), .MIRROR(MIRROR)) u_elem (
        .bar    (cfg[s*HALF + e]),
        .a_data (pre_d[s][2*e]),
        .b_data (pre_d[s][2*e+1]),
        .a_deg  (pre_x[s][2*e]),
        .b_deg  (pre_x[s][2*e+1]),
        .x_data (post_d[s][2*e]),
        .y_data (post_d[s][2*e+1]),
        .x_deg  (post_x[s][2*e]),
        .y_deg  (post_x[s][2*e+1])
      );
    end
    if (s < STAGES - 1) begin : g_wire
      for (genvar p = 0; p < N; p++) begin : g_line
        localparam int DST = benes_pkg::next_line(N, s, p);
        assign pre_d[s+1][DST] = post_d[s][p];
        assign pre_x[s+1][DST] = post_x[s][p];
      end
    end
  end
endmodule

// File: rtl/benes_loss_fabric.sv
module benes_loss_fabric #(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter bit MIRROR = 1'b0,
  localparam int LG     = $clog2(N),
  localparam int STAGES = 2 * LG - 1,
  localparam int CFGW   = STAGES * (N / 2),
  localparam int IW     = $clog2(2 * LG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N*W-1:0]  in_data,
  input  logic [CFGW-1:0] in_cfg,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N*W-1:0]  out_data,
  output logic [N*IW-1:0] out_deg
);
  logic [N*W-1:0]  net_data;
  logic [N*IW-1:0] net_deg;
  logic            take;

  benes_network #(.N(N), .W(W), .MIRROR(MIRROR)) u_net (
    .in_data  (in_data),
    .cfg      (in_cfg),
    .out_data (net_data),
    .out_deg  (net_deg)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_deg   <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_data <= net_data;
        out_deg  <= net_deg;
      end
    end
  end

  // Sum of the registered indices, used by the total-loss property.
  int deg_sum;
  always_comb begin
    deg_sum = 0;
    for (int o = 0; o < N; o++) deg_sum += int'(out_deg[o*IW +: IW]);
  end

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_deg)));

  p_total_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (deg_sum == $past(2 * $countones(in_cfg ^ {CFGW{MIRROR}}))));

  for (genvar o = 0; o < N; o++) begin : g_bound
    p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_deg[o*IW +: IW]) <= STAGES));
  end

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/benes_loss_fabric_tb.sv
module benes_loss_fabric_tb;
  localparam int PERIOD = 10;
  localparam int W   = 8;
  localparam int NA  = 4;
  localparam int NC  = 8;
  localparam int CWA = 6;
  localparam int CWC = 20;
  localparam int IWA = 2;
  localparam int IWC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic rdy = 1'b1;
  logic [NA*W-1:0] din_a = '0;
  logic [NC*W-1:0] din_c = '0;
  logic [CWA-1:0]  cfg_a = '0;
  logic [CWC-1:0]  cfg_c = '0;

  logic a_ir, b_ir, c_ir, a_ov, b_ov, c_ov;
  logic [NA*W-1:0]   a_do, b_do;
  logic [NC*W-1:0]   c_do;
  logic [NA*IWA-1:0] a_dg, b_dg;
  logic [NC*IWC-1:0] c_dg;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  benes_loss_fabric #(.N(NA), .W(W), .MIRROR(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(a_ir), .in_data(din_a),
    .in_cfg(cfg_a), .out_valid(a_ov), .out_ready(rdy), .out_data(a_do), .out_deg(a_dg));

  benes_loss_fabric #(.N(NA), .W(W), .MIRROR(1'b1)) u_dut_mir (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(b_ir), .in_data(din_a),
    .in_cfg(cfg_a), .out_valid(b_ov), .out_ready(rdy), .out_data(b_do), .out_deg(b_dg));

  benes_loss_fabric #(.N(NC), .W(W), .MIRROR(1'b0)) u_dut_big (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_ready(c_ir), .in_data(din_c),
    .in_cfg(cfg_c), .out_valid(c_ov), .out_ready(rdy), .out_data(c_do), .out_deg(c_dg));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Follows input lane i through an n-port fabric; returns output line and lossy count.
  task automatic trace(input int n, input logic [63:0] cfg, input bit mir, input int i,
                       output int o, output int d);
    int lg, st, p, blk, half, base, q;
    bit b;
    lg = $clog2(n); st = 2*lg - 1; p = i; d = 0;
    for (int s = 0; s < st; s++) begin
      b = cfg[s*(n/2) + p/2];
      d += int'(b ^ mir);
      if (!b) p = p ^ 1;
      if (s < st - 1) begin
        if (s < lg - 1) blk = n >> s;
        else            blk = n >> (st - 2 - s);
        half = blk / 2; base = p - (p % blk); q = p % blk;
        if (s < lg - 1) p = base + (q % 2) * half + q / 2;
        else            p = base + 2 * (q % half) + q / half;
      end
    end
    o = p;
  endtask

  function automatic logic [W-1:0] word(input int i, input int k);
    return W'(i * 37 + k * 5 + 1);
  endfunction

  task automatic load(input int k, input logic [CWA-1:0] ca, input logic [CWC-1:0] cc);
    cfg_a = ca; cfg_c = cc;
    for (int i = 0; i < NA; i++) din_a[i*W +: W] = word(i, k);
    for (int i = 0; i < NC; i++) din_c[i*W +: W] = word(i, k);
  endtask

  task automatic verify(input int k);
    int o, d, od, ma;
    for (int i = 0; i < NA; i++) begin
      trace(NA, 64'(cfg_a), 1'b0, i, o, d);
      chk(a_do[o*W +: W] == word(i, k), "R1 R2 R3 route normal", int'(a_do[o*W +: W]), int'(word(i, k)));
      chk(int'(a_dg[o*IWA +: IWA]) == d, "R4 normal index", int'(a_dg[o*IWA +: IWA]), d);
      trace(NA, 64'(cfg_a), 1'b1, i, o, ma);
      chk(b_do[o*W +: W] == word(i, k), "R1 route mirrored", int'(b_do[o*W +: W]), int'(word(i, k)));
      chk(int'(b_dg[o*IWA +: IWA]) == 3 - d, "R5 mirrored index", int'(b_dg[o*IWA +: IWA]), 3 - d);
    end
    for (int i = 0; i < NC; i++) begin
      trace(NC, 64'(cfg_c), 1'b0, i, o, od);
      chk(c_do[o*W +: W] == word(i, k), "R3 route 8-port", int'(c_do[o*W +: W]), int'(word(i, k)));
      chk(int'(c_dg[o*IWC +: IWC]) == od, "R4 index 8-port", int'(c_dg[o*IWC +: IWC]), od);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!a_ov && !b_ov && !c_ov, "R9 reset valid", int'(a_ov), 0);
    chk(a_ir, "R7 ready when empty", int'(a_ir), 1);
    rst_n = 1'b1;

    for (int k = 0; k < 264; k++) begin
      @(negedge clk);
      load(k, CWA'(k), CWC'($urandom));
      vld = 1'b1;
      @(posedge clk);
      @(negedge clk);
      vld = 1'b0;
      chk(a_ov && b_ov && c_ov, "R7 valid after accept", int'(a_ov), 1);
      verify(k);
    end

    // All-bar configuration: worst case in the normal plane, zero in the mirrored one.
    @(negedge clk);
    load(7, '1, '1);
    vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    for (int o = 0; o < NA; o++) begin
      chk(int'(a_dg[o*IWA +: IWA]) == 3, "R6 all-bar normal", int'(a_dg[o*IWA +: IWA]), 3);
      chk(int'(b_dg[o*IWA +: IWA]) == 0, "R6 all-bar mirrored", int'(b_dg[o*IWA +: IWA]), 0);
      chk(a_do[o*W +: W] == word(o, 7), "R2 bar keeps lane", int'(a_do[o*W +: W]), int'(word(o, 7)));
    end
    for (int o = 0; o < NC; o++)
      chk(int'(c_dg[o*IWC +: IWC]) == 5, "R6 all-bar 8-port", int'(c_dg[o*IWC +: IWC]), 5);

    // Back-pressure: stall the consumer and disturb the inputs.
    @(negedge clk);
    rdy = 1'b0;
    load(11, 6'b000000, '0);
    vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(a_ov, "R7 valid under stall", int'(a_ov), 1);
    chk(!a_ir, "R7 ready low when full", int'(a_ir), 0);
    verify(11);
    load(12, 6'b101101, 20'hABCDE);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(a_ov, "R8 still valid", int'(a_ov), 1);
    load(11, 6'b000000, '0);
    verify(11);
    vld = 1'b0;
    rdy = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!a_ov && !c_ov, "R7 drain clears valid", int'(a_ov), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule